// File: doc/BRIEF.md
# Programmable-Fabric Control Peripheral

This block is a bus peripheral that lets a processor drive a small programmable logic fabric through an APB slave port. Software streams configuration words into the fabric's configuration memory one write at a time. Each write produces a one-cycle strobe with the word and an automatically advancing configuration address. A programmable prescaler turns the system clock into a fabric clock-enable pulse, and the same control can shut the fabric clock off completely.

The fabric has 64 inputs and 64 outputs, split into eight 8-bit banks. For each input bank a select bit chooses between the primary input pins and a software-written register. Software can read every output bank. A soft-clear command returns the configuration address, the input registers and the source selection to zero without touching the prescaler, so that a new bitstream can be loaded at any time.

Top module: `fabric_ctl_apb`

## Requirements
- R1: The APB port completes every transfer with no wait states: `pready` is always 1, `pslverr` is always 0, and a write takes effect on the clock edge that ends its access phase (`psel`, `penable` and `pwrite` high).
- R2: A write to offset 0x00 drives `cfg_we` high for exactly the next cycle, with `cfg_wdata` equal to the written word and `cfg_waddr` equal to the configuration address. That address starts at 0, advances by one after each such write and wraps at 2^10. Reading 0x00 returns the next address to be used.
- R3: The divide value lives in bits 16:0 at offset 0x04. A write whose 32-bit value exceeds 65536 is stored as 65536, and reads return the stored value.
- R4: With a divide value D from 1 to 65536, `fab_ce` is high for one cycle in every D. The first pulse comes in the D-th cycle after the write edge, and the counter restarts on every write to 0x04, so D = 1 keeps `fab_ce` high continuously.
- R5: With a divide value of 0, `fab_ce` stays low.
- R6: Bit k of offset 0x08 (bits 7:0) selects the source of `fab_in[8k+7:8k]`. A 1 selects input register bank k and a 0 selects `pin_in[8k+7:8k]`. The change takes effect from the cycle after the write.
- R7: Input register bank k is at offset 0x10 + 4k, bits 7:0, and can be written and read back. Bits 31:8 are ignored on write and read as 0.
- R8: A read of offset 0x30 + 4k returns `fab_out[8k+7:8k]` in bits 7:0, with zeros above.
- R9: A write to 0x08 with bit 31 set clears the configuration address, all input registers and the source selection, and discards the other bits of that write. The divide value is kept.
- R10: Reads of unmapped or misaligned offsets return 0, and no read changes any state.
- R11: After reset every register reads 0, the prescaler is off and no configuration strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error, always 0 |
| pin_in | input | 64 | Primary input pins toward the fabric |
| fab_out | input | 64 | Outputs of the fabric |
| fab_in | output | 64 | Inputs driven into the fabric |
| fab_ce | output | 1 | Fabric clock-enable pulse |
| cfg_we | output | 1 | Configuration word strobe |
| cfg_waddr | output | 10 | Configuration memory address |
| cfg_wdata | output | 32 | Configuration word |

## Verification
A divide-value write can land on the very cycle in which the prescaler would raise `fab_ce`. Configuration strobes can also overlap a running prescaler. The bench reprograms the divider several times while it is counting and mixes configuration writes between those updates. A per-cycle behavioural model decides, for every cycle, whether the old divide value still owns the current cycle and when the restarted count produces its first pulse. `fab_ce`, the strobe outputs and `fab_in` are checked against that model on every clock.

// File: rtl/fabric_ctl_pkg.sv
// Shared constants and types for the fabric control peripheral.
// Assumes a 32-bit data path; the soft-clear bit sits at bit 31.
package fabric_ctl_pkg;
    localparam int OFF_LOAD     = 'h00;
    localparam int OFF_DIV      = 'h04;
    localparam int OFF_SEL      = 'h08;
    localparam int OFF_IN_BASE  = 'h10;
    localparam int SOFT_CLR_BIT = 31;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_LOAD,
        RK_DIV,
        RK_SEL,
        RK_IN,
        RK_OUT
    } reg_kind_t;
endpackage

// File: rtl/fabric_cfg_streamer.sv
// Emits one configuration word per push with a one-cycle strobe and an
// auto-incrementing address. Assumes pushes are never in back-to-back
// cycles on the same request (APB needs two cycles per transfer).
module fabric_cfg_streamer #(
    parameter int DATA_W = 32,
    parameter int CFG_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              soft_clr,
    output logic              cfg_we,
    output logic [CFG_AW-1:0] cfg_waddr,
    output logic [DATA_W-1:0] cfg_wdata,
    output logic [CFG_AW-1:0] next_addr
);
    logic [CFG_AW-1:0] addr_q;

    // Register the outgoing word and advance the address on each push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            cfg_we    <= 1'b0;
            cfg_waddr <= '0;
            cfg_wdata <= '0;
        end else begin
            cfg_we <= push;
            if (push) begin
                cfg_wdata <= push_data;
                cfg_waddr <= addr_q;
                addr_q    <= addr_q + 1'b1;
            end else if (soft_clr) begin
                addr_q <= '0;
            end
        end
    end

    assign next_addr = addr_q;
endmodule

// File: rtl/fabric_clk_prescaler.sv
// Produces a single-cycle enable every div_q system cycles; a value of 0
// stops the enable. Loading a new value restarts the count from zero.
// Assumes load_val is already clamped by the caller.
module fabric_clk_prescaler #(
    parameter int DIV_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    output logic [DIV_W-1:0] div_val,
    output logic             ce
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;
    logic             run;

    // Enable fires on the last count of each period.
    always_comb begin
        run = (div_q != '0);
        ce  = run && (cnt_q == div_q - 1'b1);
    end

    // Hold the divide value and step the period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            div_q <= load_val;
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= ce ? '0 : cnt_q + 1'b1;
        end
    end

    assign div_val = div_q;
endmodule

// File: rtl/fabric_io_banks.sv
// Holds the software-written input banks and the per-bank source select,
// and forms the fabric input vector. Assumes at most one bank write per
// cycle and that soft_clr never coincides with a bank write.
module fabric_io_banks #(
    parameter int N_BANKS = 8,
    parameter int BANK_W  = 8,
    parameter int BIDX_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bank_we,
    input  logic [BIDX_W-1:0]         bank_idx,
    input  logic [BANK_W-1:0]         bank_wdata,
    input  logic                      sel_we,
    input  logic [N_BANKS-1:0]        sel_wdata,
    input  logic                      soft_clr,
    input  logic [N_BANKS*BANK_W-1:0] pin_in,
    output logic [N_BANKS*BANK_W-1:0] in_flat,
    output logic [N_BANKS-1:0]        sel,
    output logic [N_BANKS*BANK_W-1:0] fab_in
);
    logic [N_BANKS-1:0] sel_q;

    // Source-select register, cleared by reset or soft clear.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            sel_q <= '0;
        end else if (sel_we) begin
            sel_q <= sel_wdata;
        end
    end

    assign sel = sel_q;

    for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
        logic [BANK_W-1:0] reg_q;

        // One input register bank.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_clr) begin
                reg_q <= '0;
            end else if (bank_we && (bank_idx == BIDX_W'(g))) begin
                reg_q <= bank_wdata;
            end
        end

        // Route register or pins into this slice of the fabric inputs.
        always_comb begin
            in_flat[g*BANK_W +: BANK_W] = reg_q;
            fab_in[g*BANK_W +: BANK_W]  = sel_q[g] ? reg_q : pin_in[g*BANK_W +: BANK_W];
        end
    end
endmodule

// File: rtl/fabric_ctl_apb.sv
// APB slave that controls a programmable fabric: configuration streaming,
// clock-enable prescaler, banked input registers with source select, and
// banked output readback. Zero-wait, never errors. Assumes DATA_W = 32.
module fabric_ctl_apb #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int N_BANKS = 8,
    parameter int BANK_W  = 8,
    parameter int DIV_W   = 17,
    parameter int CFG_AW  = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      psel,
    input  logic                      penable,
    input  logic                      pwrite,
    input  logic [ADDR_W-1:0]         paddr,
    input  logic [DATA_W-1:0]         pwdata,
    output logic [DATA_W-1:0]         prdata,
    output logic                      pready,
    output logic                      pslverr,
    input  logic [N_BANKS*BANK_W-1:0] pin_in,
    input  logic [N_BANKS*BANK_W-1:0] fab_out,
    output logic [N_BANKS*BANK_W-1:0] fab_in,
    output logic                      fab_ce,
    output logic                      cfg_we,
    output logic [CFG_AW-1:0]         cfg_waddr,
    output logic [DATA_W-1:0]         cfg_wdata
);
    import fabric_ctl_pkg::*;

    localparam int BIDX_W  = (N_BANKS > 1) ? $clog2(N_BANKS) : 1;
    localparam int DIV_MAX = 1 << (DIV_W - 1);
    localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFF_LOAD);
    localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(OFF_DIV);
    localparam logic [ADDR_W-1:0] A_SEL   = ADDR_W'(OFF_SEL);
    localparam logic [ADDR_W-1:0] A_IN    = ADDR_W'(OFF_IN_BASE);
    localparam logic [ADDR_W-1:0] A_OUT   = ADDR_W'(OFF_IN_BASE + 4 * N_BANKS);
    localparam logic [ADDR_W-1:0] A_END   = ADDR_W'(OFF_IN_BASE + 8 * N_BANKS);

    reg_kind_t                 kind;
    logic [ADDR_W-1:0]         off_in;
    logic [ADDR_W-1:0]         off_out;
    logic [BIDX_W-1:0]         bank_idx;
    logic                      wr_acc;
    logic                      soft_clr;
    logic [DIV_W-1:0]          div_load;
    logic [DIV_W-1:0]          div_val;
    logic [CFG_AW-1:0]         cfg_next;
    logic [N_BANKS*BANK_W-1:0] in_flat;
    logic [N_BANKS-1:0]        src_sel;

    // Decode the address into a register kind and bank index.
    always_comb begin
        off_in  = paddr - A_IN;
        off_out = paddr - A_OUT;
        kind    = RK_NONE;
        bank_idx = '0;
        if (paddr[1:0] == 2'b00) begin
            if (paddr == A_LOAD) begin
                kind = RK_LOAD;
            end else if (paddr == A_DIV) begin
                kind = RK_DIV;
            end else if (paddr == A_SEL) begin
                kind = RK_SEL;
            end else if (paddr >= A_IN && paddr < A_OUT) begin
                kind     = RK_IN;
                bank_idx = off_in[BIDX_W+1:2];
            end else if (paddr >= A_OUT && paddr < A_END) begin
                kind     = RK_OUT;
                bank_idx = off_out[BIDX_W+1:2];
            end
        end
    end

    // Qualify the write strobe and derive per-function commands.
    always_comb begin
        wr_acc   = psel && penable && pwrite;
        soft_clr = wr_acc && (kind == RK_SEL) && pwdata[SOFT_CLR_BIT];
        div_load = (pwdata > DATA_W'(DIV_MAX)) ? DIV_W'(DIV_MAX) : pwdata[DIV_W-1:0];
    end

    fabric_cfg_streamer #(
        .DATA_W (DATA_W),
        .CFG_AW (CFG_AW)
    ) u_stream (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_acc && (kind == RK_LOAD)),
        .push_data (pwdata),
        .soft_clr  (soft_clr),
        .cfg_we    (cfg_we),
        .cfg_waddr (cfg_waddr),
        .cfg_wdata (cfg_wdata),
        .next_addr (cfg_next)
    );

    fabric_clk_prescaler #(
        .DIV_W (DIV_W)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_acc && (kind == RK_DIV)),
        .load_val (div_load),
        .div_val  (div_val),
        .ce       (fab_ce)
    );

    fabric_io_banks #(
        .N_BANKS (N_BANKS),
        .BANK_W  (BANK_W),
        .BIDX_W  (BIDX_W)
    ) u_io (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_we    (wr_acc && (kind == RK_IN)),
        .bank_idx   (bank_idx),
        .bank_wdata (pwdata[BANK_W-1:0]),
        .sel_we     (wr_acc && (kind == RK_SEL) && !pwdata[SOFT_CLR_BIT]),
        .sel_wdata  (pwdata[N_BANKS-1:0]),
        .soft_clr   (soft_clr),
        .pin_in     (pin_in),
        .in_flat    (in_flat),
        .sel        (src_sel),
        .fab_in     (fab_in)
    );

    // Read data mux; anything unmapped returns zero.
    always_comb begin
        prdata = '0;
        if (psel) begin
            unique case (kind)
                RK_LOAD: prdata = DATA_W'(cfg_next);
                RK_DIV:  prdata = DATA_W'(div_val);
                RK_SEL:  prdata = DATA_W'(src_sel);
                RK_IN:   prdata = DATA_W'(in_flat[bank_idx*BANK_W +: BANK_W]);
                RK_OUT:  prdata = DATA_W'(fab_out[bank_idx*BANK_W +: BANK_W]);
                default: prdata = '0;
            endcase
        end
    end

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
endmodule

// File: rtl/fabric_ctl_chk.sv
// Property checker for fabric_ctl_apb, attached with bind below.
// Observes ports and the source-select state of the top module.
module fabric_ctl_chk #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int N_BANKS = 8,
    parameter int BANK_W  = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      psel,
    input logic                      penable,
    input logic                      pwrite,
    input logic [ADDR_W-1:0]         paddr,
    input logic [DATA_W-1:0]         pwdata,
    input logic [DATA_W-1:0]         prdata,
    input logic                      fab_ce,
    input logic                      cfg_we,
    input logic [DATA_W-1:0]         cfg_wdata,
    input logic [N_BANKS*BANK_W-1:0] pin_in,
    input logic [N_BANKS*BANK_W-1:0] fab_in,
    input logic [N_BANKS-1:0]        src_sel
);
    logic wr_acc;
    assign wr_acc = psel && penable && pwrite;

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !cfg_we); // R2

    AST_STROBE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && paddr == '0) |=> (cfg_we && cfg_wdata == $past(pwdata))); // R2

    AST_CE_DIV_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && paddr == ADDR_W'(4) && pwdata == DATA_W'(1)) |=> fab_ce); // R4

    AST_CE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && paddr == ADDR_W'(4) && pwdata == '0) |=> !fab_ce); // R5

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && paddr == ADDR_W'('h0C)) |-> (prdata == '0)); // R10

    for (genvar g = 0; g < N_BANKS; g++) begin : g_mux
        AST_PIN_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
            !src_sel[g] |-> (fab_in[g*BANK_W +: BANK_W] == pin_in[g*BANK_W +: BANK_W])); // R6
    end
endmodule

bind fabric_ctl_apb fabric_ctl_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .N_BANKS (N_BANKS),
    .BANK_W  (BANK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .prdata    (prdata),
    .fab_ce    (fab_ce),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .pin_in    (pin_in),
    .fab_in    (fab_in),
    .src_sel   (src_sel)
);

// File: tb/fabric_ctl_apb_tb.sv
// Self-checking bench with a behavioural per-cycle reference model.
module fabric_ctl_apb_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [63:0] pin_in = '0, fab_out = '0;
    logic [63:0] fab_in;
    logic        fab_ce, cfg_we;
    logic [9:0]  cfg_waddr;
    logic [31:0] cfg_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int          m_div = 0, m_cnt = 0, m_caddr = 0, m_waddr = 0;
    bit          m_we = 0;
    logic [31:0] m_wdata = '0;
    logic [7:0]  m_in [8];
    logic [7:0]  m_sel = '0;
    int          ce_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fabric_ctl_apb u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .pin_in(pin_in), .fab_out(fab_out), .fab_in(fab_in),
        .fab_ce(fab_ce), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata)
    );

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // model update on each clock edge
    always @(posedge clk) begin
        bit wr;
        wr = psel && penable && pwrite;
        if (!rst_n) begin
            m_div = 0; m_cnt = 0; m_caddr = 0; m_we = 0; m_sel = '0;
            foreach (m_in[k]) m_in[k] = '0;
        end else begin
            m_we = wr && paddr == 8'h00;
            if (m_we) begin
                m_wdata = pwdata; m_waddr = m_caddr; m_caddr = (m_caddr + 1) % 1024;
            end
            if (wr && paddr == 8'h04) begin
                m_div = (pwdata > 32'd65536) ? 65536 : int'(pwdata); m_cnt = 0;
            end else if (m_div != 0) begin
                m_cnt = (m_cnt == m_div - 1) ? 0 : m_cnt + 1;
            end
            if (wr && paddr == 8'h08) begin
                if (pwdata[31]) begin
                    m_caddr = 0; m_sel = '0;
                    foreach (m_in[k]) m_in[k] = '0;
                end else m_sel = pwdata[7:0];
            end
            if (wr && paddr >= 8'h10 && paddr < 8'h30 && paddr[1:0] == 2'b00)
                m_in[(paddr - 8'h10) >> 2] = pwdata[7:0];
        end
    end

    function automatic logic [63:0] exp_fab_in();
        logic [63:0] v;
        for (int k = 0; k < 8; k++)
            v[k*8 +: 8] = m_sel[k] ? m_in[k] : pin_in[k*8 +: 8];
        return v;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        if (a[1:0] != 2'b00) return '0;
        if (a == 8'h00) return 32'(m_caddr);
        if (a == 8'h04) return 32'(m_div);
        if (a == 8'h08) return {24'h0, m_sel};
        if (a >= 8'h10 && a < 8'h30) return {24'h0, m_in[(a - 8'h10) >> 2]};
        if (a >= 8'h30 && a < 8'h50) return {24'h0, fab_out[((a - 8'h30) >> 2) * 8 +: 8]};
        return '0;
    endfunction

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            logic ece;
            ece = (m_div != 0) && (m_cnt == m_div - 1);
            if (fab_ce) ce_seen++;
            check("R4", "fab_ce", 64'(fab_ce), 64'(ece));
            check("R2", "cfg_we", 64'(cfg_we), 64'(m_we));
            if (m_we) begin
                check("R2", "cfg_wdata", 64'(cfg_wdata), 64'(m_wdata));
                check("R2", "cfg_waddr", 64'(cfg_waddr), 64'(m_waddr));
            end
            check("R6", "fab_in", fab_in, exp_fab_in());
        end
    end

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input string req, input logic [7:0] a);
        logic [31:0] e;
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1;
        #2;
        e = exp_rd(a);
        check(req, $sformatf("read %h", a), 64'(prdata), 64'(e));
        check("R1", "pready/pslverr", {62'h0, pready, pslverr}, 64'h2);
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        foreach (m_in[k]) m_in[k] = '0;
        idle(3);
        rst_n = 1;
        idle(2);
        // R11: reset state
        check("R11", "cfg_we after reset", 64'(cfg_we), 64'h0);
        check("R11", "fab_ce after reset", 64'(fab_ce), 64'h0);
        apb_rd("R11", 8'h00); apb_rd("R11", 8'h04); apb_rd("R11", 8'h08);
        apb_rd("R11", 8'h10);

        // R2: configuration streaming
        apb_wr(8'h00, 32'hDEADBEEF);
        apb_wr(8'h00, 32'h12345678);
        apb_wr(8'h00, 32'h0BADF00D);
        apb_rd("R2", 8'h00);

        // R4: divide by 1, then by 5, reprogram mid-count
        apb_wr(8'h04, 32'd1);  idle(6);
        apb_wr(8'h04, 32'd5);  idle(13);
        apb_wr(8'h00, 32'hCAFE0001);
        apb_wr(8'h04, 32'd3);  idle(4);
        apb_wr(8'h04, 32'd4);  idle(9);
        apb_rd("R4", 8'h04);

        // R5: divide value zero stops the enable
        apb_wr(8'h04, 32'd0);
        ce_seen = 0;
        idle(30);
        check("R5", "fab_ce pulses while off", 64'(ce_seen), 64'h0);

        // R3: clamp and read-back
        apb_wr(8'h04, 32'h0002_0000); apb_rd("R3", 8'h04);
        apb_wr(8'h04, 32'd65536);     apb_rd("R3", 8'h04);
        apb_wr(8'h04, 32'd65535);     apb_rd("R3", 8'h04);
        apb_wr(8'h04, 32'd7);         idle(10);

        // R7: input banks, upper bits ignored
        for (int k = 0; k < 8; k++) apb_wr(8'h10 + 8'(4*k), 32'hFFFF_FF00 | 32'(8'h11 * (k + 1)));
        for (int k = 0; k < 8; k++) apb_rd("R7", 8'h10 + 8'(4*k));

        // R6: source select mix
        pin_in = 64'h0123_4567_89AB_CDEF;
        apb_wr(8'h08, 32'h0000_00A5);
        apb_rd("R6", 8'h08);
        idle(2);
        pin_in = 64'hF0E1_D2C3_B4A5_9687;
        idle(2);
        check("R6", "fab_in mixed", fab_in, exp_fab_in());

        // R8: output readback
        fab_out = 64'h5A69_7887_96A5_B4C3;
        for (int k = 0; k < 8; k++) apb_rd("R8", 8'h30 + 8'(4*k));

        // R10: unmapped and misaligned reads
        apb_rd("R10", 8'h0C); apb_rd("R10", 8'h50); apb_rd("R10", 8'h11); apb_rd("R10", 8'hFC);
        apb_rd("R10", 8'h00);

        // R9: soft clear keeps the prescaler
        apb_wr(8'h08, 32'h8000_00FF);
        apb_rd("R9", 8'h00); apb_rd("R9", 8'h08); apb_rd("R9", 8'h14); apb_rd("R9", 8'h04);
        check("R9", "fab_in follows pins", fab_in, pin_in);
        apb_wr(8'h00, 32'h0000_0042);
        apb_rd("R9", 8'h00);
        idle(4);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule